// File: doc/BRIEF.md
# Master-Slave Dual PWM Timer Group

This block is a three-channel timer group. A master channel sets a shared PWM period. Two slave channels each time one pulse inside that period. The master counts down on a prescaled count clock and produces a period event. Each slave is a one-shot counter that the period event starts. The slave raises its output pin when it starts and drops the pin when its count completes. The two slave pins therefore give two PWM waveforms with a common period and independent duty cycles.

Configuration arrives as static register-style inputs. These select the count clock source, the operating mode and start-trigger source of each slave, and per-channel output settings: output enable, active level, direct latch value and output mode. Every channel has a one-cycle interrupt output. Channel 0 is the master. Channels 1 and 2 are the slaves, numbered above it.

Top module: `mspwm_timer`

## Requirements
- R1: After reset, `tout` and `irq` are all zero.
- R2: Each of two dividers gives a count tick once every `div_x`+1 clock cycles. `clk_sel` = 2'b00 selects divider A and 2'b10 selects divider B, for all three channels. Codes 2'b01 and 2'b11 give no count tick, so all counters hold.
- R3: In the cycle where `run` is first seen high, the master emits a period event. It emits another every `per_data`+1 count ticks after that. Each event appears on `irq[0]` one cycle later.
- R4: A slave is in one-count mode only when `slv_mode[i][3:1]` = 3'b100, and is started only when `slv_trig[i]` = 3'b100 (the master period event). Any other mode or trigger code leaves that slave idle.
- R5: A slave start loads `slv_duty[i]`. The slave completes after that many count ticks and pulses `irq[i+1]` one cycle later. A duty of 0 completes in the start cycle itself.
- R6: With `slv_mode[i][0]` = 1, a start during counting reloads the count, so a duty above `per_data` holds the output active for the whole period. With bit 0 = 0, a start during counting is ignored.
- R7: With `omode[i]` = 1, a slave pin goes active on start and inactive on completion, and completion wins when both occur together. With `omode[i]` = 0, the slave pin toggles on completion. The master pin toggles on every period event.
- R8: When `olvl[ch]` = 0 the channel is active-high (active = 1). When it is 1 the channel is active-low (active = 0).
- R9: When `oen[ch]` = 0, `tout[ch]` equals `olat[ch]` one cycle later, and counting events have no effect on it.
- R10: A change to `slv_duty[i]` during a pulse does not change that pulse. It applies from the next start.
- R11: With `run` low, counters stop, slaves drop their busy state, no interrupts occur, and pins keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Group run enable; rising level starts the master |
| clk_sel | input | 2 | Count clock select (00 = divider A, 10 = divider B) |
| div_a | input | PRE_W | Divider A ratio minus one |
| div_b | input | PRE_W | Divider B ratio minus one |
| per_data | input | CNT_W | Master period minus one, in count ticks |
| slv_duty | input | 2 x CNT_W | Pulse width of each slave, in count ticks |
| slv_mode | input | 2 x 4 | Slave mode; 1001 one-count retriggerable, 1000 one-count |
| slv_trig | input | 2 x 3 | Slave start source; 100 = master period event |
| oen | input | 3 | Per-channel counting output enable |
| olvl | input | 3 | Per-channel active level (1 = active-low) |
| olat | input | 3 | Per-channel direct output value used when disabled |
| omode | input | 2 | Slave output mode (1 = set/reset, 0 = toggle) |
| tout | output | 3 | Timer output pins, channel 0 is master |
| irq | output | 3 | One-cycle interrupt per channel |

## Verification
Every event is decided in the cycle where the counters see it, and it reaches `tout` and `irq` through exactly one register. All results are therefore due at the edge after the triggering cycle. A master start in cycle c shows its interrupt and the slave set at c+1. With a one-cycle count tick, a slave of duty D shows its completion at c+D+1. The bench keeps a behavioural model that follows these latencies. It drives inputs on the falling edge and compares every output on the falling edge after each rising edge. Window counts of high cycles and interrupt pulses then confirm duty, 0%/100%, retrigger and disabled-output behaviour in absolute numbers.

// File: rtl/mspwm_pkg.sv
package mspwm_pkg;
  localparam int NUM_SLV = 2;
  localparam int NUM_CH  = NUM_SLV + 1;

  localparam logic [2:0] TRG_MASTER = 3'b100;
  localparam logic [1:0] CKS_A      = 2'b00;
  localparam logic [1:0] CKS_B      = 2'b10;

  // one-count family: upper three mode bits equal 100
  function automatic logic is_one_count(input logic [3:0] m);
    return m[3:1] == 3'b100;
  endfunction

  // next pin value from the enable, latch, level and the cycle's events
  function automatic logic next_pin(input logic en, input logic latch,
                                    input logic lvl, input logic setclr,
                                    input logic cur, input logic set_ev,
                                    input logic clr_ev, input logic tog_ev);
    if (!en) return latch;
    if (setclr) begin
      if (clr_ev) return lvl;
      if (set_ev) return ~lvl;
      return cur;
    end
    if (tog_ev) return ~cur;
    return cur;
  endfunction
endpackage

// File: rtl/mspwm_tick.sv
module mspwm_tick import mspwm_pkg::*; #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic [PRE_W-1:0] div_a,
  input  logic [PRE_W-1:0] div_b,
  output logic             tick
);
  logic [PRE_W-1:0] ratio [2];
  logic [PRE_W-1:0] pc    [2];
  logic [1:0]       hit;

  assign ratio[0] = div_a;
  assign ratio[1] = div_b;

  for (genvar g = 0; g < 2; g++) begin : g_div
    assign hit[g] = pc[g] >= ratio[g];
    always_ff @(posedge clk) begin
      if (!rst_n)      pc[g] <= '0;
      else if (hit[g]) pc[g] <= '0;
      else             pc[g] <= pc[g] + PRE_W'(1);
    end
    // R2
    div_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> pc[g] == '0);
  end

  always_comb begin
    unique case (sel)
      CKS_A:   tick = hit[0];
      CKS_B:   tick = hit[1];
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/mspwm_master.sv
module mspwm_master #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] per,
  output logic             evt
);
  logic             act;
  logic [CNT_W-1:0] cnt;
  logic             start_ev, wrap_ev;

  assign start_ev = run && !act;
  assign wrap_ev  = run && act && tick && (cnt == '0);
  assign evt      = start_ev || wrap_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (!run) begin
      act <= 1'b0;
    end else if (start_ev) begin
      act <= 1'b1;
      cnt <= per;
    end else if (tick) begin
      cnt <= (cnt == '0) ? per : cnt - CNT_W'(1);
    end
  end

  // R3
  period_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> cnt == $past(per));
  // R11
  evt_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !act);
endmodule

// File: rtl/mspwm_slave.sv
module mspwm_slave import mspwm_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             m_evt,
  input  logic [3:0]       mode,
  input  logic [2:0]       trig,
  input  logic [CNT_W-1:0] duty,
  output logic             set_ev,
  output logic             done_ev
);
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             armed, trg, last;

  assign armed   = is_one_count(mode) && (trig == TRG_MASTER);
  assign trg     = run && armed && m_evt && (!busy || mode[0]);
  assign last    = busy && tick && (cnt == CNT_W'(1));
  assign set_ev  = trg;
  assign done_ev = run && ((trg && duty == '0) || (last && !trg));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!run) begin
      busy <= 1'b0;
    end else if (trg) begin
      cnt  <= duty;
      busy <= duty != '0;
    end else if (busy && tick) begin
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) busy <= 1'b0;
    end
  end

  // R5
  load_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trg && duty != '0) |=> (busy && cnt == $past(duty)));
  // R5
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> !busy);
  // R4
  idle_when_unarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !busy) |=> !busy);
endmodule

// File: rtl/mspwm_timer.sv
module mspwm_timer import mspwm_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           run,
  input  logic [1:0]                     clk_sel,
  input  logic [PRE_W-1:0]               div_a,
  input  logic [PRE_W-1:0]               div_b,
  input  logic [CNT_W-1:0]               per_data,
  input  logic [NUM_SLV-1:0][CNT_W-1:0]  slv_duty,
  input  logic [NUM_SLV-1:0][3:0]        slv_mode,
  input  logic [NUM_SLV-1:0][2:0]        slv_trig,
  input  logic [NUM_CH-1:0]              oen,
  input  logic [NUM_CH-1:0]              olvl,
  input  logic [NUM_CH-1:0]              olat,
  input  logic [NUM_SLV-1:0]             omode,
  output logic [NUM_CH-1:0]              tout,
  output logic [NUM_CH-1:0]              irq
);
  logic               tick;
  logic               m_evt;
  logic [NUM_SLV-1:0] s_set, s_done;

  mspwm_tick #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(clk_sel),
    .div_a(div_a), .div_b(div_b), .tick(tick)
  );

  mspwm_master #(.CNT_W(CNT_W)) u_master (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .per(per_data), .evt(m_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tout[0] <= 1'b0;
      irq[0]  <= 1'b0;
    end else begin
      tout[0] <= next_pin(oen[0], olat[0], olvl[0], 1'b0, tout[0],
                          1'b0, 1'b0, m_evt);
      irq[0]  <= m_evt;
    end
  end

  for (genvar i = 0; i < NUM_SLV; i++) begin : g_slv
    mspwm_slave #(.CNT_W(CNT_W)) u_slv (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .m_evt(m_evt),
      .mode(slv_mode[i]), .trig(slv_trig[i]), .duty(slv_duty[i]),
      .set_ev(s_set[i]), .done_ev(s_done[i])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tout[i+1] <= 1'b0;
        irq[i+1]  <= 1'b0;
      end else begin
        tout[i+1] <= next_pin(oen[i+1], olat[i+1], olvl[i+1], omode[i],
                              tout[i+1], s_set[i], s_done[i], s_done[i]);
        irq[i+1]  <= s_done[i];
      end
    end

    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_done[i] && oen[i+1] && omode[i]) |=> tout[i+1] == $past(olvl[i+1]));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_pin
    // R9
    latch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oen[c] |=> tout[c] == $past(olat[c]));
  end

  // R11
  quiet_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> irq == '0);
endmodule

// File: tb/mspwm_timer_tb.sv
module mspwm_timer_tb;
  localparam int CW = 16;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [1:0] clk_sel = 2'b00;
  logic [PW-1:0] div_a = '0, div_b = '0;
  logic [CW-1:0] per_data = '0;
  logic [1:0][CW-1:0] slv_duty = '0;
  logic [1:0][3:0] slv_mode = '0;
  logic [1:0][2:0] slv_trig = '0;
  logic [2:0] oen = '0, olvl = '0, olat = '0;
  logic [1:0] omode = '0;
  logic [2:0] tout, irq;

  always #2 clk = ~clk;

  mspwm_timer #(.CNT_W(CW), .PRE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_sel(clk_sel),
    .div_a(div_a), .div_b(div_b), .per_data(per_data),
    .slv_duty(slv_duty), .slv_mode(slv_mode), .slv_trig(slv_trig),
    .oen(oen), .olvl(olvl), .olat(olat), .omode(omode),
    .tout(tout), .irq(irq)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit fin = 0;

  // behavioural reference model
  int pa, pb, m_left, s_left[2];
  bit m_on, s_busy[2];
  bit [2:0] e_tout, e_irq;

  always @(posedge clk) begin
    bit ta, tb, tk, mev, acc, sev, sdn;
    if (!rst_n) begin
      pa = 0; pb = 0; m_on = 0; m_left = 0;
      s_busy = '{0, 0}; s_left = '{0, 0};
      e_tout = 0; e_irq = 0;
    end else begin
      ta = (pa >= int'(div_a)); tb = (pb >= int'(div_b));
      pa = ta ? 0 : pa + 1;     pb = tb ? 0 : pb + 1;
      tk = (clk_sel == 2'b00) ? ta : (clk_sel == 2'b10) ? tb : 1'b0;
      mev = 0;
      if (!run) m_on = 0;
      else if (!m_on) begin m_on = 1; m_left = int'(per_data); mev = 1; end
      else if (tk) begin
        if (m_left == 0) begin mev = 1; m_left = int'(per_data); end
        else m_left--;
      end
      e_irq[0] = mev;
      if (!oen[0]) e_tout[0] = olat[0];
      else if (mev) e_tout[0] = ~e_tout[0];
      for (int s = 0; s < 2; s++) begin
        sev = 0; sdn = 0;
        if (!run) s_busy[s] = 0;
        else begin
          acc = mev && slv_mode[s][3:1] == 3'b100 && slv_trig[s] == 3'b100 &&
                (!s_busy[s] || slv_mode[s][0]);
          if (acc) begin
            sev = 1;
            if (slv_duty[s] == 0) begin sdn = 1; s_busy[s] = 0; end
            else begin s_busy[s] = 1; s_left[s] = int'(slv_duty[s]); end
          end else if (s_busy[s] && tk) begin
            s_left[s]--;
            if (s_left[s] == 0) begin s_busy[s] = 0; sdn = 1; end
          end
        end
        e_irq[s+1] = sdn;
        if (!oen[s+1]) e_tout[s+1] = olat[s+1];
        else if (omode[s]) begin
          if (sdn) e_tout[s+1] = olvl[s+1];
          else if (sev) e_tout[s+1] = ~olvl[s+1];
        end else if (sdn) e_tout[s+1] = ~e_tout[s+1];
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      n_cmp++;
      if (tout !== e_tout || irq !== e_irq) begin
        n_bad++;
        $display("FAIL %s model: tout=%b irq=%b expected tout=%b irq=%b",
                 cur_req, tout, irq, e_tout, e_irq);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int hi[3], ip[3];
  task automatic win(input int n);
    hi = '{0, 0, 0}; ip = '{0, 0, 0};
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      for (int c = 0; c < 3; c++) begin
        hi[c] += int'(tout[c]); ip[c] += int'(irq[c]);
      end
    end
  endtask

  task automatic stop_clear();
    logic [2:0] keep;
    cur_req = "R11";
    run = 0; repeat (3) @(negedge clk);
    keep = oen; oen = 0; olat = 0;
    cur_req = "R9";
    repeat (2) @(negedge clk);
    oen = keep;
  endtask

  task automatic base();
    clk_sel = 2'b00; div_a = 0; div_b = 0; per_data = 9;
    slv_duty[0] = 3; slv_duty[1] = 7;
    slv_mode[0] = 4'b1001; slv_mode[1] = 4'b1001;
    slv_trig[0] = 3'b100; slv_trig[1] = 3'b100;
    oen = 3'b111; olvl = 0; olat = 0; omode = 2'b11;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 tout", int'(tout), 0);
    chk("R1 irq", int'(irq), 0);
    base();
    @(negedge clk);

    // R3 R5 R7 nominal PWM
    cur_req = "R5"; run = 1; win(60);
    chk("R3 master irq count", ip[0], 6);
    chk("R5 slave1 high cycles", hi[1], 18);
    chk("R5 slave2 high cycles", hi[2], 42);
    chk("R5 slave1 irq count", ip[1], 6);
    stop_clear();

    // R8 active-low slaves
    cur_req = "R8"; olvl = 3'b110; run = 1; win(60);
    chk("R8 slave1 high cycles", hi[1], 42);
    chk("R8 slave2 high cycles", hi[2], 18);
    stop_clear(); olvl = 0;

    // R5 0% and R6 100%
    cur_req = "R6"; slv_duty[0] = 0; slv_duty[1] = 12; run = 1; win(60);
    chk("R5 zero duty high", hi[1], 0);
    chk("R5 zero duty irq", ip[1], 6);
    chk("R6 over-period high", hi[2], 60);
    chk("R6 retrigger no completion", ip[2], 0);
    stop_clear();

    // R6 non-retriggerable
    cur_req = "R6"; slv_mode[1] = 4'b1000; run = 1; win(60);
    chk("R6 no-retrigger completions", ip[2], 3);
    stop_clear(); base();

    // R2 invalid select gives no tick
    cur_req = "R2"; clk_sel = 2'b01; run = 1; win(60);
    chk("R2 no tick master irq", ip[0], 1);
    stop_clear();

    // R2 divider B
    cur_req = "R2"; clk_sel = 2'b10; div_b = 2; per_data = 3; run = 1; win(80);
    stop_clear(); base();

    // R9 outputs disabled follow latch
    cur_req = "R9"; oen = 0; olat = 3'b101; run = 1; win(40);
    chk("R9 pin0 latched", hi[0], 40);
    chk("R9 pin1 latched", hi[1], 0);
    chk("R9 pin2 latched", hi[2], 40);
    chk("R9 counting continues", ip[0], 4);
    olat = 3'b010; win(5);
    chk("R9 latch rewrite", int'(tout), 2);
    stop_clear(); base();

    // R10 duty change mid-pulse
    cur_req = "R10"; slv_duty[0] = 6; run = 1; win(2);
    slv_duty[0] = 2; win(8);
    chk("R10 first pulse kept", hi[1] + 2, 6);
    win(10);
    chk("R10 new duty next period", hi[1], 2);
    stop_clear(); base();

    // R4 non-master trigger leaves slave idle
    cur_req = "R4"; slv_trig[0] = 3'b000; slv_mode[1] = 4'b0001; run = 1; win(40);
    chk("R4 slave1 idle", ip[1], 0);
    chk("R4 slave2 idle", ip[2], 0);
    stop_clear(); base();

    // R7 toggle output mode
    cur_req = "R7"; omode = 2'b00; run = 1; win(40);
    chk("R7 toggle completions", ip[1], 4);
    chk("R7 toggle high", hi[1], 20);
    // R11 stop holds pins
    cur_req = "R11"; run = 0; win(1);
    begin
      logic [2:0] held;
      held = tout; win(10);
      chk("R11 pins held", int'(tout), int'(held));
      chk("R11 no irq", ip[0] + ip[1] + ip[2], 0);
    end

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      fin = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule